// File: doc/BRIEF.md
# Cascadable Chained-Tap FIR Filter

This block is an eight-tap finite impulse response filter made from two identical tiles of four multipliers. Each tile holds four sample registers. Each register can load from its own external input or from the register before it in a shift chain. The tile multiplies its four registered samples by four stored coefficients and registers the sum of the four products. The chain runs from the last register of the first tile into the first register of the second tile. This makes one continuous delay line of eight taps. An adder outside the tiles combines the two tile sums into the filter output.

In normal use both tiles are set to chain mode. A new sample enters at the head of the chain on every cycle where the input valid is high. The output is then the convolution of the input stream with the eight coefficients. Each tile can also be switched to external mode. In that mode its four registers all load from a wide parallel sample port in the same cycle, so any mix of parallel loading and chaining can be built per tile. Coefficients are written one at a time through an address/data port while no samples are moving.

Top module: `fir_chain_top`

## Requirements
- R1: With both tiles in chain mode (src_sel bit = 0), each accepted output equals the sum over k = 0..7 of coef[k] * x[n-k], where x[n] is the newest accepted sample and samples older than the last reset count as zero; all values are signed two's complement.
- R2: The tap registers change only on cycles where in_valid is high; idle cycles between samples leave the results of later samples unchanged.
- R3: out_valid is high exactly three clock cycles after a cycle with in_valid high, and is low in every other cycle.
- R4: The chain crosses the tile boundary: a single nonzero sample followed by zeros produces outputs proportional to coef[0], coef[1], ... coef[7] in that order.
- R5: When src_sel bit t is 1 on an accepted cycle, the four taps of tile t (global tap index 4t+j) all load from ext_samples bits [(4t+j)*18 +: 18] in that cycle.
- R6: Per-tile selection is independent: a tile in chain mode takes its first tap from the previous tile's last tap (or from in_sample for tile 0), whatever mode the other tile is in.
- R7: A write with coef_we high stores coef_data as the coefficient of tap coef_addr, where tap 0 is the newest sample and tap 7 the oldest.
- R8: A synchronous active-high reset clears all taps, coefficients and pipeline stages: out_valid is low and out_data is zero in the cycle after reset, and later samples see a zero history.
- R9: The output is wide enough never to overflow: with every sample and coefficient equal to -131072, the steady output is exactly +2^37.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept a sample and advance the taps this cycle |
| in_sample | input | 18 | Signed sample entering the head of the chain |
| src_sel | input | 2 | Per-tile tap source, 0 = chain, 1 = external |
| ext_samples | input | 144 | Parallel signed samples, 18 bits per tap, tap 0 lowest |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 3 | Tap index of the coefficient written |
| coef_data | input | 18 | Signed coefficient value |
| out_valid | output | 1 | out_data holds a new filter result |
| out_data | output | 39 | Signed filter result |

## Verification
The assertions assume that coefficient writes happen only while the pipeline is empty, with no accepted sample in the three cycles before or during a write. They also assume src_sel is sampled only on accepted cycles. The bench keeps to this rule: before every coefficient load it drains the pipeline with idle cycles. It compares each output against a convolution of its own shadow taps and coefficients. That shadow copy is advanced by the chain or external rule for each tile. The stimulus covers impulse and step inputs, random data with random idle gaps, all four tile-mode patterns, full-scale negative values, and a reset in the middle of a stream.

// File: rtl/fir_chain_pkg.sv
package fir_chain_pkg;

  typedef enum logic {
    SRC_CHAIN = 1'b0,
    SRC_EXT   = 1'b1
  } tap_src_e;

endpackage

// File: rtl/fir_tap_reg.sv
module fir_tap_reg
  import fir_chain_pkg::*;
#(
  parameter int DW = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  tap_src_e             src,
  input  logic signed [DW-1:0] ext_d,
  input  logic signed [DW-1:0] chain_d,
  output logic signed [DW-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (shift_en) begin
      q <= (src == SRC_EXT) ? ext_d : chain_d;
    end
  end

endmodule

// File: rtl/fir_tile.sv
module fir_tile
  import fir_chain_pkg::*;
#(
  parameter int DW   = 18,
  parameter int CW   = 18,
  parameter int TAPS = 4,
  localparam int TW  = $clog2(TAPS),
  localparam int PW  = DW + CW,
  localparam int SW  = PW + TW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   shift_en,
  input  tap_src_e               src_sel,
  input  logic signed [DW-1:0]   chain_in,
  input  logic [TAPS*DW-1:0]     ext_in,
  input  logic                   coef_we,
  input  logic [TW-1:0]          coef_idx,
  input  logic signed [CW-1:0]   coef_d,
  input  logic                   sum_en,
  output logic signed [DW-1:0]   chain_out,
  output logic signed [SW-1:0]   tile_sum
);

  logic signed [DW-1:0] tap_q [TAPS];
  logic signed [CW-1:0] coef  [TAPS];
  logic signed [PW-1:0] prod  [TAPS];
  logic signed [SW-1:0] acc;

  for (genvar j = 0; j < TAPS; j++) begin : g_tap
    logic signed [DW-1:0] link_d;
    if (j == 0) begin : g_head
      assign link_d = chain_in;
    end else begin : g_body
      assign link_d = tap_q[j-1];
    end

    fir_tap_reg #(.DW(DW)) tap_i (
      .clk      (clk),
      .rst      (rst),
      .shift_en (shift_en),
      .src      (src_sel),
      .ext_d    ($signed(ext_in[j*DW +: DW])),
      .chain_d  (link_d),
      .q        (tap_q[j])
    );

    AST_TAP_HOLD: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> $stable(tap_q[j])); // R2
    AST_EXT_LOAD: assert property (@(posedge clk) disable iff (rst)
      (shift_en && src_sel == SRC_EXT) |=> tap_q[j] == $past($signed(ext_in[j*DW +: DW]))); // R5
    if (j > 0) begin : g_chk_chain
      AST_CHAIN_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (shift_en && src_sel == SRC_CHAIN) |=> tap_q[j] == $past(tap_q[j-1])); // R1
    end
    AST_COEF_WRITE: assert property (@(posedge clk) disable iff (rst)
      (coef_we && coef_idx == TW'(j)) |=> coef[j] == $past(coef_d)); // R7
  end

  assign chain_out = tap_q[TAPS-1];

  always_ff @(posedge clk) begin
    for (int j = 0; j < TAPS; j++) begin
      if (rst) begin
        coef[j] <= '0;
      end else if (coef_we && coef_idx == TW'(j)) begin
        coef[j] <= coef_d;
      end
    end
  end

  always_comb begin
    acc = '0;
    for (int j = 0; j < TAPS; j++) begin
      prod[j] = tap_q[j] * coef[j];
      acc     = acc + {{TW{prod[j][PW-1]}}, prod[j]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tile_sum <= '0;
    end else if (sum_en) begin
      tile_sum <= acc;
    end
  end

endmodule

// File: rtl/fir_sum_adder.sv
module fir_sum_adder #(
  parameter int SW = 38,
  parameter int NT = 2,
  parameter int OW = 39
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [NT*SW-1:0]     parts,
  output logic signed [OW-1:0] total
);

  logic signed [OW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int t = 0; t < NT; t++) begin
      acc = acc + OW'($signed(parts[t*SW +: SW]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      total <= '0;
    end else if (en) begin
      total <= acc;
    end
  end

endmodule

// File: rtl/fir_chain_top.sv
module fir_chain_top
  import fir_chain_pkg::*;
#(
  parameter int DW            = 18,
  parameter int CW            = 18,
  parameter int TAPS_PER_TILE = 4,
  parameter int NUM_TILES     = 2,
  localparam int NTAPS = TAPS_PER_TILE * NUM_TILES,
  localparam int AW    = $clog2(NTAPS),
  localparam int TW    = $clog2(TAPS_PER_TILE),
  localparam int PW    = DW + CW,
  localparam int SW    = PW + TW,
  localparam int OW    = SW + $clog2(NUM_TILES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic signed [DW-1:0]   in_sample,
  input  logic [NUM_TILES-1:0]   src_sel,
  input  logic [NTAPS*DW-1:0]    ext_samples,
  input  logic                   coef_we,
  input  logic [AW-1:0]          coef_addr,
  input  logic signed [CW-1:0]   coef_data,
  output logic                   out_valid,
  output logic signed [OW-1:0]   out_data
);

  localparam logic signed [OW:0] OUT_LIM = (OW+1)'(NTAPS) << (PW - 2);

  logic                 v_tap, v_sum;
  logic signed [DW-1:0] chain_q [NUM_TILES];
  logic [NUM_TILES*SW-1:0] sums_flat;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_tap     <= 1'b0;
      v_sum     <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v_tap     <= in_valid;
      v_sum     <= v_tap;
      out_valid <= v_sum;
    end
  end

  for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
    logic signed [DW-1:0] head_d;
    logic                 we_t;
    logic [TW-1:0]        idx_t;
    logic signed [SW-1:0] sum_t;

    if (t == 0) begin : g_first
      assign head_d = in_sample;
    end else begin : g_next
      assign head_d = chain_q[t-1];
    end

    assign we_t  = coef_we && ((int'(coef_addr) / TAPS_PER_TILE) == t);
    assign idx_t = TW'(int'(coef_addr) % TAPS_PER_TILE);

    fir_tile #(.DW(DW), .CW(CW), .TAPS(TAPS_PER_TILE)) tile_i (
      .clk       (clk),
      .rst       (rst),
      .shift_en  (in_valid),
      .src_sel   (tap_src_e'(src_sel[t])),
      .chain_in  (head_d),
      .ext_in    (ext_samples[t*TAPS_PER_TILE*DW +: TAPS_PER_TILE*DW]),
      .coef_we   (we_t),
      .coef_idx  (idx_t),
      .coef_d    (coef_data),
      .sum_en    (v_tap),
      .chain_out (chain_q[t]),
      .tile_sum  (sum_t)
    );

    assign sums_flat[t*SW +: SW] = sum_t;
  end

  fir_sum_adder #(.SW(SW), .NT(NUM_TILES), .OW(OW)) final_i (
    .clk   (clk),
    .rst   (rst),
    .en    (v_sum),
    .parts (sums_flat),
    .total (out_data)
  );

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
    end else if (since_rst != 2'd3) begin
      since_rst <= since_rst + 2'd1;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> out_valid == $past(in_valid, 3)); // R3
  AST_VALID_EARLY: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd3) |-> !out_valid); // R3
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    ($signed({out_data[OW-1], out_data}) <= OUT_LIM) &&
    ($signed({out_data[OW-1], out_data}) >= -OUT_LIM)); // R9
  AST_TAIL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(chain_q[NUM_TILES-1])); // R2

endmodule

// File: tb/fir_chain_top_tb_top.sv
`timescale 1ns/1ps
module fir_chain_top_tb_top;

  localparam int DW = 18;
  localparam int NT = 8;
  localparam int OW = 39;

  logic              clk = 1'b0;
  logic              rst;
  logic              in_valid;
  logic signed [DW-1:0] in_sample;
  logic [1:0]        src_sel;
  logic [NT*DW-1:0]  ext_samples;
  logic              coef_we;
  logic [2:0]        coef_addr;
  logic signed [DW-1:0] coef_data;
  logic              out_valid;
  logic signed [OW-1:0] out_data;

  always #4 clk = ~clk;

  fir_chain_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .src_sel(src_sel), .ext_samples(ext_samples), .coef_we(coef_we),
    .coef_addr(coef_addr), .coef_data(coef_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0;
  int failures = 0;

  longint mx [NT];
  longint mc [NT];
  bit     pv [3];
  longint py [3];
  string  pr [3];
  string  cur_req = "R1";

  function automatic longint rnd18();
    logic signed [DW-1:0] r;
    r = DW'($urandom);
    return longint'(r);
  endfunction

  function automatic longint conv();
    longint s = 0;
    for (int k = 0; k < NT; k++) s += mc[k] * mx[k];
    return s;
  endfunction

  task automatic check_val(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  // advance one cycle with inputs already driven; maintain expected pipe
  task automatic tick();
    longint old [NT];
    if (in_valid) begin
      for (int k = 0; k < NT; k++) old[k] = mx[k];
      for (int t = 0; t < 2; t++) begin
        for (int j = 0; j < 4; j++) begin
          int i = t*4 + j;
          if (src_sel[t]) mx[i] = longint'($signed(ext_samples[i*DW +: DW]));
          else if (j > 0) mx[i] = old[i-1];
          else if (t == 0) mx[i] = longint'(in_sample);
          else mx[i] = old[i-1];
        end
      end
    end
    if (coef_we) mc[coef_addr] = longint'(coef_data);
    pv[2] = pv[1]; py[2] = py[1]; pr[2] = pr[1];
    pv[1] = pv[0]; py[1] = py[0]; pr[1] = pr[0];
    pv[0] = in_valid; py[0] = conv(); pr[0] = cur_req;
    @(posedge clk);
    @(negedge clk);
    check_val("R3 out_valid", longint'(out_valid), longint'(pv[2]));
    if (out_valid && pv[2]) check_val(pr[2], longint'(out_data), py[2]);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0; coef_we = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic sample(input longint s);
    in_valid = 1'b1; coef_we = 1'b0;
    in_sample = DW'(s);
    tick();
    in_valid = 1'b0;
  endtask

  task automatic load_coef(input int a, input longint v);
    in_valid = 1'b0; coef_we = 1'b1;
    coef_addr = 3'(a); coef_data = DW'(v);
    tick();
    coef_we = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; coef_we = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_val("R8 out_valid after reset", longint'(out_valid), 0);
    check_val("R8 out_data after reset", longint'(out_data), 0);
    for (int k = 0; k < NT; k++) begin mx[k] = 0; mc[k] = 0; end
    for (int k = 0; k < 3; k++) begin pv[k] = 1'b0; py[k] = 0; pr[k] = ""; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired got=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_sample = '0; src_sel = 2'b00;
    ext_samples = '0; coef_we = 1'b0; coef_addr = '0; coef_data = '0;
    @(negedge clk);
    do_reset();

    // R7 / R4: impulse through each coefficient set, chain crosses tiles
    cur_req = "R4 impulse";
    for (int set = 0; set < 3; set++) begin
      idle(3);
      for (int k = 0; k < NT; k++) load_coef(k, (k + 1) * 1000 * (set + 1) - 4100 * set);
      sample(1 + set);
      for (int i = 0; i < 10; i++) sample(0);
    end

    // R7: single-address writes hit only their tap
    cur_req = "R7 single coef";
    for (int a = 0; a < NT; a++) begin
      idle(3);
      for (int k = 0; k < NT; k++) load_coef(k, 0);
      load_coef(a, 777 + a);
      sample(-5);
      for (int i = 0; i < 9; i++) sample(0);
    end

    // R1: step input
    cur_req = "R1 step";
    idle(3);
    for (int k = 0; k < NT; k++) load_coef(k, 3000 - 900 * k);
    for (int i = 0; i < 16; i++) sample(1234);

    // R1/R2: random data with random idle gaps
    for (int set = 0; set < 4; set++) begin
      cur_req = "R2 random gaps";
      idle(3);
      for (int k = 0; k < NT; k++) load_coef(k, rnd18());
      for (int i = 0; i < 80; i++) begin
        if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 4));
        sample(rnd18());
      end
    end

    // R5: both tiles external
    cur_req = "R5 external";
    idle(3);
    for (int k = 0; k < NT; k++) load_coef(k, rnd18());
    src_sel = 2'b11;
    for (int i = 0; i < 40; i++) begin
      for (int k = 0; k < NT; k++) ext_samples[k*DW +: DW] = DW'($urandom);
      sample(rnd18());
    end

    // R6: every mix of tile modes
    cur_req = "R6 mixed modes";
    for (int i = 0; i < 120; i++) begin
      src_sel = 2'($urandom);
      for (int k = 0; k < NT; k++) ext_samples[k*DW +: DW] = DW'($urandom);
      sample(rnd18());
    end
    src_sel = 2'b00;

    // R9: full-scale negative values
    cur_req = "R9 full scale";
    idle(3);
    for (int k = 0; k < NT; k++) load_coef(k, -131072);
    for (int i = 0; i < 12; i++) sample(-131072);
    idle(3);
    check_val("R9 steady output", longint'(out_data), 64'sd137438953472);

    // R8: reset mid-stream, then zero history
    cur_req = "R8 after reset";
    for (int i = 0; i < 2; i++) sample(rnd18());
    do_reset();
    for (int k = 0; k < NT; k++) load_coef(k, 100 + k);
    sample(50);
    sample(-7);
    idle(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule